// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

The controller collects a wide bundle of peripheral interrupt lines into numbered groups. Groups are numbered from 8 to 26 and each holds up to 32 sources. Each source line passes through a two-flop synchronizer. A rising edge then latches a status bit, which software clears by writing ones. A per-source enable word, changed only through separate set and clear addresses, masks the status into a read-only result word.

Each group raises one aggregated output, which is the OR of its result bits. That output is gated by a block-enable bit at the bit position equal to the group number. Groups 8 to 12 and 24 to 26 are aggregated-only. Every other group also drives one direct output per source, equal to that source's result bit.

Software reaches all state through a word-addressed register bus. A read returns its data one cycle after the request.

Top module: `gia_ctrl`

## Requirements
- R1: After reset every status, enable and block-enable bit is zero, so `aggr_o` and `direct_o` are all zero and every register reads as zero.
- R2: A rising edge on a source input sets its status bit. The bit is readable at word address (group-8)*4+0 four cycles after the input changes. A falling edge, or a level held high after the bit is cleared, sets nothing.
- R3: Writing the status address clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: If a new rising edge and a clear write reach the same status bit in the same cycle, the bit ends up set.
- R5: Ones written to address (group-8)*4+1 set enable bits, and ones written to (group-8)*4+2 clear them. A read of either address returns the current enable word.
- R6: The result word at address (group-8)*4+3 equals status AND enable. Writes to that address change nothing.
- R7: `aggr_o[group-8]` is the OR of that group's result bits, gated by the block-enable bit at bit position equal to the group number.
- R8: Ones written to word address 0x60 set block-enable bits, and ones written to 0x61 clear them. Address 0x62 reads the block-enable word. A write of all ones to 0x61 drops every aggregated output on the next cycle.
- R9: For direct-capable groups, `direct_o[(group-8)*NUM_SRC+bit]` equals the result bit. For groups 8 to 12 and 24 to 26, every direct output is zero.
- R10: Source positions at or above `NUM_SRC` are not implemented. They read as zero in the status, enable and result words, and writing ones to them has no effect.
- R11: `rvalid_o` rises exactly one cycle after each read request, with `rdata_o` valid in that cycle, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_GRP*NUM_SRC | Asynchronous source lines, group index major |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| aggr_o | output | NUM_GRP | Gated aggregated output per group |
| direct_o | output | NUM_GRP*NUM_SRC | Direct per-source outputs |

## Verification
The hardest case to reach is the collision of R4, where the synchronized edge and a clear write land on the same status bit in the same cycle. The stimulus raises the source line at a falling clock edge. It then counts two rising edges through the synchronizer and issues the clear write so that it is sampled on the third edge, when the edge detector fires. The expected status is therefore still set. A second case clears a bit while its source is held high, which shows that only edges are latched.

// File: rtl/gia_pkg.sv
package gia_pkg;
  localparam int REG_W        = 32;
  localparam int GRP_STRIDE   = 4;
  localparam int OFS_STAT     = 0;
  localparam int OFS_EN_SET   = 1;
  localparam int OFS_EN_CLR   = 2;
  localparam int OFS_RESULT   = 3;
  localparam int BLK_SET_ADDR = 'h60;
  localparam int BLK_CLR_ADDR = 'h61;
  localparam int BLK_RD_ADDR  = 'h62;

  typedef struct packed {
    logic stat_clr;
    logic en_set;
    logic en_clr;
  } grp_wr_t;
endpackage

// File: rtl/gia_edge_sync.sv
module gia_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/gia_group.sv
module gia_group
  import gia_pkg::*;
#(
  parameter int NUM_SRC   = 24,
  parameter bit DIRECT_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] rise_i,
  input  grp_wr_t            wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] result_o,
  output logic               any_o,
  output logic [NUM_SRC-1:0] direct_o
);
  logic [NUM_SRC-1:0] stat_q, en_q, stat_clr, en_d;

  assign stat_clr = wr_i.stat_clr ? wdata_i : '0;

  always_comb begin
    en_d = en_q;
    if (wr_i.en_set) en_d = en_q | wdata_i;
    if (wr_i.en_clr) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      // a fresh edge overrides a clear in the same cycle
      stat_q <= (stat_q & ~stat_clr) | rise_i;
      en_q   <= en_d;
    end
  end

  assign stat_o   = stat_q;
  assign en_o     = en_q;
  assign result_o = stat_q & en_q;
  assign any_o    = |result_o;

  generate
    if (DIRECT_EN) begin : g_direct
      assign direct_o = result_o;
    end else begin : g_no_direct
      assign direct_o = '0;
    end
  endgenerate
endmodule

// File: rtl/gia_blk_en.sv
module gia_blk_en
  import gia_pkg::*;
#(
  parameter int FIRST_GRP = 8,
  parameter int NUM_GRP   = 19
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NUM_GRP-1:0] blk_o,
  output logic [REG_W-1:0]   word_o
);
  localparam int HI = FIRST_GRP + NUM_GRP - 1;

  logic [NUM_GRP-1:0] blk_q, sel;

  assign sel = wdata_i[HI:FIRST_GRP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    blk_q <= '0;
    else if (set_i) blk_q <= blk_q | sel;
    else if (clr_i) blk_q <= blk_q & ~sel;
  end

  assign blk_o  = blk_q;
  assign word_o = REG_W'(blk_q) << FIRST_GRP;
endmodule

// File: rtl/gia_ctrl.sv
module gia_ctrl
  import gia_pkg::*;
#(
  parameter int                 FIRST_GRP      = 8,
  parameter int                 NUM_GRP        = 19,
  parameter int                 NUM_SRC        = 24,
  parameter int                 ADDR_W         = 8,
  parameter logic [NUM_GRP-1:0] AGGR_ONLY_MASK = 19'h7001F
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_GRP*NUM_SRC-1:0] src_i,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic                       rvalid_o,
  output logic [REG_W-1:0]           rdata_o,
  output logic [NUM_GRP-1:0]         aggr_o,
  output logic [NUM_GRP*NUM_SRC-1:0] direct_o
);
  localparam int SRC_TOT = NUM_GRP * NUM_SRC;
  localparam int SEL_W   = ADDR_W - 2;

  logic [SRC_TOT-1:0] rise;
  logic [SEL_W-1:0]   grp_sel;
  logic [1:0]         ofs;
  logic               wr, rd;
  logic [NUM_GRP-1:0] blk_en, grp_any;
  logic [REG_W-1:0]   blk_word, rdata_d, rdata_q;
  logic               rvalid_q;

  logic [NUM_SRC-1:0] stat_w   [NUM_GRP];
  logic [NUM_SRC-1:0] en_w     [NUM_GRP];
  logic [NUM_SRC-1:0] result_w [NUM_GRP];

  assign grp_sel = addr_i[ADDR_W-1:2];
  assign ofs     = addr_i[1:0];
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;

  gia_edge_sync #(.W(SRC_TOT)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(src_i),
    .rise_o (rise)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      grp_wr_t wr_g;
      logic    hit;

      assign hit          = wr && (int'(grp_sel) == g);
      assign wr_g.stat_clr = hit && (int'(ofs) == OFS_STAT);
      assign wr_g.en_set   = hit && (int'(ofs) == OFS_EN_SET);
      assign wr_g.en_clr   = hit && (int'(ofs) == OFS_EN_CLR);

      gia_group #(
        .NUM_SRC  (NUM_SRC),
        .DIRECT_EN(!AGGR_ONLY_MASK[g])
      ) u_grp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (rise[g*NUM_SRC +: NUM_SRC]),
        .wr_i    (wr_g),
        .wdata_i (wdata_i[NUM_SRC-1:0]),
        .stat_o  (stat_w[g]),
        .en_o    (en_w[g]),
        .result_o(result_w[g]),
        .any_o   (grp_any[g]),
        .direct_o(direct_o[g*NUM_SRC +: NUM_SRC])
      );
    end
  endgenerate

  gia_blk_en #(
    .FIRST_GRP(FIRST_GRP),
    .NUM_GRP  (NUM_GRP)
  ) u_blk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr && (addr_i == ADDR_W'(BLK_SET_ADDR))),
    .clr_i  (wr && (addr_i == ADDR_W'(BLK_CLR_ADDR))),
    .wdata_i(wdata_i),
    .blk_o  (blk_en),
    .word_o (blk_word)
  );

  assign aggr_o = grp_any & blk_en;

  always_comb begin
    rdata_d = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (int'(grp_sel) == g) begin
        unique case (int'(ofs))
          OFS_STAT:   rdata_d = REG_W'(stat_w[g]);
          OFS_RESULT: rdata_d = REG_W'(result_w[g]);
          default:    rdata_d = REG_W'(en_w[g]);
        endcase
      end
    end
    if (addr_i == ADDR_W'(BLK_SET_ADDR) || addr_i == ADDR_W'(BLK_CLR_ADDR) ||
        addr_i == ADDR_W'(BLK_RD_ADDR))
      rdata_d = blk_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/gia_ctrl_chk.sv
module gia_ctrl_chk
  import gia_pkg::*;
#(
  parameter int                 NUM_GRP        = 19,
  parameter int                 NUM_SRC        = 24,
  parameter int                 ADDR_W         = 8,
  parameter int                 FIRST_GRP      = 8,
  parameter logic [NUM_GRP-1:0] AGGR_ONLY_MASK = 19'h7001F
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [REG_W-1:0]           wdata_i,
  input logic                       rvalid_o,
  input logic [REG_W-1:0]           rdata_o,
  input logic [NUM_GRP-1:0]         aggr_o,
  input logic [NUM_GRP*NUM_SRC-1:0] direct_o,
  input logic [NUM_GRP-1:0]         blk_en_i
);
  a_r11_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  a_r8_clear_all_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(BLK_CLR_ADDR) &&
     (&wdata_i[FIRST_GRP+NUM_GRP-1:FIRST_GRP])) |=> (aggr_o == '0));

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
      a_r7_aggr_needs_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        aggr_o[g] |-> blk_en_i[g]);
      if (AGGR_ONLY_MASK[g]) begin : g_ao
        a_r9_aggr_only_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
          direct_o[g*NUM_SRC +: NUM_SRC] == '0);
      end else begin : g_dc
        a_r9_direct_implies_aggr: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ((|direct_o[g*NUM_SRC +: NUM_SRC]) && blk_en_i[g]) |-> aggr_o[g]);
      end
    end
    if (NUM_SRC < REG_W) begin : g_unimpl
      a_r10_unimpl_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rvalid_o && $past(addr_i) < ADDR_W'(BLK_SET_ADDR)) |->
          (rdata_o[REG_W-1:NUM_SRC] == '0));
    end
  endgenerate
endmodule

bind gia_ctrl gia_ctrl_chk #(
  .NUM_GRP       (NUM_GRP),
  .NUM_SRC       (NUM_SRC),
  .ADDR_W        (ADDR_W),
  .FIRST_GRP     (FIRST_GRP),
  .AGGR_ONLY_MASK(AGGR_ONLY_MASK)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o),
  .aggr_o  (aggr_o),
  .direct_o(direct_o),
  .blk_en_i(blk_en)
);

// File: tb/gia_ctrl_tb_top.sv
module gia_ctrl_tb_top;
  localparam int NG = 19;
  localparam int NS = 24;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NG*NS-1:0] src = '0;
  logic            req = 1'b0, we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic            rvalid;
  logic [31:0]     rdata;
  logic [NG-1:0]   aggr;
  logic [NG*NS-1:0] direct;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gia_ctrl #(.NUM_GRP(NG), .NUM_SRC(NS), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .aggr_o(aggr), .direct_o(direct)
  );

  function automatic logic [AW-1:0] ga(int grp, int ofs);
    return AW'((grp - 8) * 4 + ofs);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // driver: push expectation, issue read
  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare read data as it appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected rvalid actual=1 expected=0");
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 aggr", 32'(aggr), 0);
    check("R1 direct", 32'(|direct), 0);
    rd(ga(13, 0), 0, "R1 status");
    rd(ga(13, 1), 0, "R1 enable");
    rd(8'h62, 0, "R1 blk");

    // R2 edge latching on group 13 bits 0 and 3
    @(negedge clk);
    src[5*NS + 0] = 1'b1;
    src[5*NS + 3] = 1'b1;
    idle(4);
    rd(ga(13, 0), 32'h9, "R2 latched");
    rd(ga(13, 3), 32'h0, "R6 result no enable");

    // R5 enable set, read through clear address
    wr(ga(13, 1), 32'h1);
    rd(ga(13, 2), 32'h1, "R5 enable via clr addr");
    rd(ga(13, 3), 32'h1, "R6 result");
    check("R9 direct g13 b0", 32'(direct[5*NS]), 1);
    check("R7 aggr gated off", 32'(aggr[5]), 0);

    // R7/R8 block enable at bit 13
    wr(8'h60, 32'h1 << 13);
    check("R7 aggr on", 32'(aggr[5]), 1);
    rd(8'h62, 32'h1 << 13, "R8 blk word");

    // R6 result is read-only
    wr(ga(13, 3), 32'h0);
    rd(ga(13, 3), 32'h1, "R6 write ignored");

    // R3 write-one-to-clear
    wr(ga(13, 0), 32'h8);
    rd(ga(13, 0), 32'h1, "R3 w1c");
    wr(ga(13, 0), 32'h0);
    rd(ga(13, 0), 32'h1, "R3 zero no effect");

    // R5 enable clear
    wr(ga(13, 2), 32'h1);
    rd(ga(13, 1), 32'h0, "R5 enable cleared");
    check("R7 aggr after disable", 32'(aggr[5]), 0);
    check("R9 direct after disable", 32'(direct[5*NS]), 0);

    // R2 falling edge and held level
    @(negedge clk);
    src[5*NS + 3] = 1'b0;
    idle(4);
    rd(ga(13, 0), 32'h1, "R2 falling no effect");
    wr(ga(13, 0), 32'h1);
    idle(4);
    rd(ga(13, 0), 32'h0, "R2 held level no relatch");

    // R9 aggregated-only group 8
    @(negedge clk);
    src[0*NS + 5] = 1'b1;
    idle(4);
    wr(ga(8, 1), 32'h20);
    wr(8'h60, 32'h1 << 8);
    check("R7 g8 aggr", 32'(aggr[0]), 1);
    check("R9 g8 no direct", 32'(|direct[0 +: NS]), 0);

    // R8 clear all then re-enable one
    wr(8'h61, 32'hFFFF_FFFF);
    check("R8 all gated", 32'(aggr), 0);
    wr(8'h60, 32'h1 << 8);
    check("R8 reenable g8 only", 32'(aggr), 1);
    rd(8'h62, 32'h100, "R8 blk word g8");

    // R10 unimplemented positions on group 26
    wr(ga(26, 1), 32'hFFFF_FFFF);
    rd(ga(26, 1), 32'h00FF_FFFF, "R10 enable upper zero");
    rd(ga(26, 0), 32'h0, "R10 status zero");

    // R4 edge and clear in the same cycle, group 13 bit 7
    @(negedge clk);
    src[5*NS + 7] = 1'b1;         // before edge 1
    @(negedge clk);               // after edge 1
    @(negedge clk);               // after edge 2: rise active now
    req = 1'b1; we = 1'b1; addr = ga(13, 0); wdata = 32'h80;
    @(negedge clk);               // edge 3: set and clear together
    req = 1'b0; we = 1'b0;
    rd(ga(13, 0), 32'h80, "R4 edge wins");

    idle(3);
    check("R11 all reads answered", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule